// File: doc/BRIEF.md
# Strided and Fragmented Read Address Generator

This block turns a decoded transfer description into a series of memory read requests. Each request carries an address and a byte length, and it moves to the memory side under a valid/ready handshake. A single start pulse loads every field the block needs. These are a control word, a transfer size, a line word, five low source addresses and the extension words that supply each source address's upper bits. The block then issues requests until its termination rule is met.

Two walking styles exist. In the line-walking style the generator reads one line per request and steps the address by a stride. In the scatter style it visits up to five separate source addresses in turn, and each read runs from the source address to the end of its 4 KiB page. A read error reported while a request is pending aborts the walk and raises one flag bit that belongs to this channel. Every walk ends with a one-cycle done pulse that reports the total number of bytes requested.

Top module: `rd_addr_seq`

## Requirements
- R1: After reset, req_valid_o, done_o and busy_o are low and err_flags_o is zero.
- R2: In line mode the first address is {ext_word_i[0][27:16], src_addr_i[0]}. Every request length is line_word_i[17:0]. Each accepted request moves the address forward by line_word_i[31:18] times 16 bytes.
- R3: In line mode, requests continue until the bytes requested reach or pass the transfer size. The final request still asks for a full line.
- R4: ctrl_i bit 18 chooses the mode: 1 gives scatter mode and 0 gives line mode. No other control bit changes the request stream.
- R5: In scatter mode, fragments are visited in the order 0..4. The address of fragment k is {ext field, src_addr_i[k]}. The ext field comes from word (k+1)/2, at bits [11:0] when k is odd and at bits [27:16] when k is even. The request length is 4096 minus the address modulo 4096.
- R6: Scatter mode stops when the remaining byte count reaches zero or goes below zero, or after the fifth fragment, whichever happens first.
- R7: When the walk ends, done_o pulses for one cycle and done_bytes_o holds the sum of accepted lengths. A transfer size of zero produces no request and reports 0.
- R8: While req_ready_i is low, no new request begins. req_valid_o, req_addr_o and req_len_o hold steady until the request is accepted.
- R9: rd_err_i high while a request is pending ends the walk with no further requests. It sets only bit 12+CHAN_IDX of err_flags_o and pulses done with the bytes accepted before the error. The next start clears the flags.
- R10: In line mode, a line length of zero produces no request and reports 0 bytes.
- R11: A start pulse that arrives while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load the fields and begin a walk (honoured only when idle) |
| ctrl_i | input | 32 | Control word; bit 18 selects scatter mode |
| xfer_size_i | input | 32 | Transfer size in bytes |
| line_word_i | input | 32 | Line length [17:0], stride in 16-byte units [31:18] |
| src_addr_i | input | 160 | Five low source addresses, fragment k at [32k+31:32k] |
| ext_word_i | input | 96 | Three extension words holding the 12-bit upper address fields |
| req_valid_o | output | 1 | Read request pending |
| req_ready_i | input | 1 | Memory side accepts the request |
| req_addr_o | output | 44 | Request byte address |
| req_len_o | output | 18 | Request byte length |
| rd_err_i | input | 1 | Read error for the pending request |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| done_bytes_o | output | 32 | Total bytes requested in the last walk |
| err_flags_o | output | 32 | Sticky error flags, bit 12+CHAN_IDX |

## Verification
The bench covers a line walk whose size is an exact multiple of the line, and one that overshoots the size. A design that compares the remaining count for equality only would never stop on the overshoot. A design that trims the last line would report the wrong total. The scatter walks include one page-aligned source, one source a single byte below a page end, and a size that exhausts all five fragments. Together these expose a wrong extension-field position, an off-by-one page length, or a walk that runs past the fifth fragment. The bench also covers zero sizes, a zero line length, stalls with a stray start pulse, and an error on the second request. These catch a design that issues a spurious request, one that drifts its address while stalled, one that restarts while busy, or one that keeps issuing after an abort.

// File: rtl/rd_addr_seq_pkg.sv
package rd_addr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // control word bit that selects scatter (fragment) walking
  localparam int unsigned MODE_BIT  = 18;
  // bit index of the data-error flag for channel 0
  localparam int unsigned ERR_BASE  = 12;
  // stride field is coded in 16-byte units
  localparam int unsigned STRIDE_SH = 4;
endpackage

// File: rtl/rd_addr_seq_rst.sv
module rd_addr_seq_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rd_addr_seq_pick.sv
module rd_addr_seq_pick #(
  parameter int unsigned FRAG_N = 5,
  parameter int unsigned LOW_AW = 32,
  parameter int unsigned EXT_W  = 12,
  parameter int unsigned IDX_W  = 3,
  localparam int unsigned EXT_WORDS = FRAG_N / 2 + 1,
  localparam int unsigned AW        = EXT_W + LOW_AW
) (
  input  logic [FRAG_N*LOW_AW-1:0] src_flat_i,
  input  logic [EXT_WORDS*32-1:0]  ext_flat_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [AW-1:0]            addr_o
);
  logic [AW-1:0] cand [FRAG_N];
  logic          unused_ext_par;

  // fragment k takes its upper bits from word (k+1)/2: low half for odd k, upper half for even k
  for (genvar k = 0; k < FRAG_N; k++) begin : g_frag
    localparam int unsigned WORD = (k + 1) / 2;
    localparam int unsigned LSB  = WORD * 32 + (((k % 2) == 1) ? 0 : 16);
    assign cand[k] = {ext_flat_i[LSB +: EXT_W], src_flat_i[k*LOW_AW +: LOW_AW]};
  end

  always_comb begin
    addr_o = '0;
    for (int k = 0; k < FRAG_N; k++) begin
      if (idx_i == IDX_W'(k)) addr_o = cand[k];
    end
  end

  assign unused_ext_par = ^ext_flat_i;
endmodule

// File: rtl/rd_addr_seq_len.sv
module rd_addr_seq_len #(
  parameter int unsigned LEN_W  = 18,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned RW     = 33,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned FRAG_N = 5
) (
  input  logic              frag_mode_i,
  input  logic [PAGE_W-1:0] addr_lo_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic [RW-1:0]     remain_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LEN_W-1:0]  cur_len_o,
  output logic [RW-1:0]     remain_nx_o,
  output logic              last_o
);
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << PAGE_W;

  logic [LEN_W-1:0] page_left;
  logic             covered;
  logic             out_of_frags;

  assign page_left   = PAGE_BYTES - LEN_W'(addr_lo_i);
  assign cur_len_o   = frag_mode_i ? page_left : line_len_i;
  assign remain_nx_o = remain_i - RW'(cur_len_o);
  // remaining count is two's complement: zero or negative ends the walk
  assign covered      = remain_nx_o[RW-1] || (remain_nx_o == '0);
  assign out_of_frags = frag_mode_i && (idx_i == IDX_W'(FRAG_N - 1));
  assign last_o       = covered || out_of_frags;
endmodule

// File: rtl/rd_addr_seq.sv
module rd_addr_seq
  import rd_addr_seq_pkg::*;
#(
  parameter int unsigned FRAG_N     = 5,
  parameter int unsigned LOW_AW     = 32,
  parameter int unsigned EXT_W      = 12,
  parameter int unsigned LINE_LEN_W = 18,
  parameter int unsigned PAGE_W     = 12,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned FLAG_W     = 32,
  parameter int unsigned CHAN_IDX   = 0,
  localparam int unsigned AW        = EXT_W + LOW_AW,
  localparam int unsigned EXT_WORDS = FRAG_N / 2 + 1,
  localparam int unsigned IDX_W     = $clog2(FRAG_N + 1),
  localparam int unsigned RW        = CNT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [31:0]               ctrl_i,
  input  logic [CNT_W-1:0]          xfer_size_i,
  input  logic [31:0]               line_word_i,
  input  logic [FRAG_N*LOW_AW-1:0]  src_addr_i,
  input  logic [EXT_WORDS*32-1:0]   ext_word_i,
  output logic                      req_valid_o,
  input  logic                      req_ready_i,
  output logic [AW-1:0]             req_addr_o,
  output logic [LINE_LEN_W-1:0]     req_len_o,
  input  logic                      rd_err_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [CNT_W-1:0]          done_bytes_o,
  output logic [FLAG_W-1:0]         err_flags_o
);
  localparam logic [FLAG_W-1:0] ERR_MASK = FLAG_W'(1) << (ERR_BASE + CHAN_IDX);

  logic rst_int_n;

  seq_state_e                state_q, state_d;
  logic                      mode_q, mode_d;
  logic [RW-1:0]             remain_q, remain_d;
  logic [CNT_W-1:0]          total_q, total_d;
  logic [AW-1:0]             addr_q, addr_d;
  logic [LINE_LEN_W-1:0]     line_q, line_d;
  logic [AW-1:0]             stride_q, stride_d;
  logic [IDX_W-1:0]          idx_q, idx_d;
  logic [FRAG_N*LOW_AW-1:0]  src_q, src_d;
  logic [EXT_WORDS*32-1:0]   ext_q, ext_d;
  logic [FLAG_W-1:0]         err_q, err_d;

  logic [AW-1:0]             first_addr;
  logic [AW-1:0]             next_frag_addr;
  logic [IDX_W-1:0]          idx_inc;
  logic [LINE_LEN_W-1:0]     cur_len;
  logic [RW-1:0]             remain_nx;
  logic                      last_req;
  logic                      empty_walk;
  logic                      accept;
  logic                      unused_ctrl_par;

  rd_addr_seq_rst #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // fragment 0 address straight from the inputs, used at load time
  rd_addr_seq_pick #(
    .FRAG_N(FRAG_N), .LOW_AW(LOW_AW), .EXT_W(EXT_W), .IDX_W(IDX_W)
  ) u_pick_first (
    .src_flat_i (src_addr_i),
    .ext_flat_i (ext_word_i),
    .idx_i      ('0),
    .addr_o     (first_addr)
  );

  assign idx_inc = idx_q + IDX_W'(1);

  // following fragment address from the captured fields
  rd_addr_seq_pick #(
    .FRAG_N(FRAG_N), .LOW_AW(LOW_AW), .EXT_W(EXT_W), .IDX_W(IDX_W)
  ) u_pick_next (
    .src_flat_i (src_q),
    .ext_flat_i (ext_q),
    .idx_i      (idx_inc),
    .addr_o     (next_frag_addr)
  );

  rd_addr_seq_len #(
    .LEN_W(LINE_LEN_W), .PAGE_W(PAGE_W), .RW(RW), .IDX_W(IDX_W), .FRAG_N(FRAG_N)
  ) u_len (
    .frag_mode_i (mode_q),
    .addr_lo_i   (addr_q[PAGE_W-1:0]),
    .line_len_i  (line_q),
    .remain_i    (remain_q),
    .idx_i       (idx_q),
    .cur_len_o   (cur_len),
    .remain_nx_o (remain_nx),
    .last_o      (last_req)
  );

  assign empty_walk = (xfer_size_i == '0) ||
                      (!ctrl_i[MODE_BIT] && (line_word_i[LINE_LEN_W-1:0] == '0));
  assign accept     = (state_q == ST_RUN) && req_ready_i && !rd_err_i;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    remain_d = remain_q;
    total_d  = total_q;
    addr_d   = addr_q;
    line_d   = line_q;
    stride_d = stride_q;
    idx_d    = idx_q;
    src_d    = src_q;
    ext_d    = ext_q;
    err_d    = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d   = ctrl_i[MODE_BIT];
          remain_d = RW'(xfer_size_i);
          total_d  = '0;
          addr_d   = first_addr;
          line_d   = line_word_i[LINE_LEN_W-1:0];
          stride_d = AW'(line_word_i[31:LINE_LEN_W]) << STRIDE_SH;
          idx_d    = '0;
          src_d    = src_addr_i;
          ext_d    = ext_word_i;
          err_d    = '0;
          state_d  = empty_walk ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (rd_err_i) begin
          err_d   = ERR_MASK;
          state_d = ST_FIN;
        end else if (req_ready_i) begin
          total_d  = total_q + CNT_W'(cur_len);
          remain_d = remain_nx;
          if (mode_q) begin
            idx_d  = idx_inc;
            addr_d = next_frag_addr;
          end else begin
            addr_d = addr_q + stride_q;
          end
          if (last_req) state_d = ST_FIN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      remain_q <= '0;
      total_q  <= '0;
      addr_q   <= '0;
      line_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      src_q    <= '0;
      ext_q    <= '0;
      err_q    <= '0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      remain_q <= remain_d;
      total_q  <= total_d;
      addr_q   <= addr_d;
      line_q   <= line_d;
      stride_q <= stride_d;
      idx_q    <= idx_d;
      src_q    <= src_d;
      ext_q    <= ext_d;
      err_q    <= err_d;
    end
  end

  assign req_valid_o  = (state_q == ST_RUN);
  assign req_addr_o   = addr_q;
  assign req_len_o    = cur_len;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign done_bytes_o = total_q;
  assign err_flags_o  = err_q;

  assign unused_ctrl_par = ^ctrl_i;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid_o && !req_ready_i && !rd_err_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !req_valid_o);

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid_o && rd_err_i) |=> (done_o && $onehot(err_flags_o)));

  // R6
  frag_bound_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid_o && mode_q) |-> (idx_q < IDX_W'(FRAG_N)));

  // R3
  stop_on_last_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && last_req) |=> (done_o && !req_valid_o));
endmodule

// File: tb/rd_addr_seq_test.sv
module rd_addr_seq_test;
  localparam int unsigned CH = 3;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [31:0]  ctrl_i;
  logic [31:0]  xfer_size_i;
  logic [31:0]  line_word_i;
  logic [159:0] src_addr_i;
  logic [95:0]  ext_word_i;
  logic         req_valid_o;
  logic         req_ready_i;
  logic [43:0]  req_addr_o;
  logic [17:0]  req_len_o;
  logic         rd_err_i;
  logic         busy_o;
  logic         done_o;
  logic [31:0]  done_bytes_o;
  logic [31:0]  err_flags_o;

  int checks   = 0;
  int failures = 0;

  logic [43:0] got_addr [16];
  logic [17:0] got_len  [16];
  int          n_req;
  bit          got_done;
  logic [31:0] got_bytes;
  logic [31:0] got_flags;
  int          hold_bad;

  rd_addr_seq #(.CHAN_IDX(CH)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
    .xfer_size_i(xfer_size_i), .line_word_i(line_word_i),
    .src_addr_i(src_addr_i), .ext_word_i(ext_word_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .rd_err_i(rd_err_i),
    .busy_o(busy_o), .done_o(done_o), .done_bytes_o(done_bytes_o),
    .err_flags_o(err_flags_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [31:0] ctrl, input logic [31:0] size,
                      input logic [31:0] line, input logic [159:0] srcs,
                      input logic [95:0] exts);
    @(negedge clk);
    ctrl_i = ctrl; xfer_size_i = size; line_word_i = line;
    src_addr_i = srcs; ext_word_i = exts; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // stall bit i low-drives ready in iteration i; err_after = request index that gets the error
  task automatic collect(input int err_after, input logic [31:0] stall, input bit poke);
    bit          prev_hold;
    logic [43:0] prev_addr;
    logic [17:0] prev_len;
    n_req = 0; got_done = 0; hold_bad = 0; prev_hold = 0;
    prev_addr = '0; prev_len = '0;
    for (int it = 0; it < 200; it++) begin
      rd_err_i = 1'b0;
      start_i  = 1'b0;
      if (poke && it == 1) begin
        start_i = 1'b1; xfer_size_i = 32'd0; ctrl_i = ctrl_i ^ 32'h0004_0000;
      end
      req_ready_i = !(it < 32 && stall[it]);
      if (prev_hold && (!req_valid_o || req_addr_o !== prev_addr || req_len_o !== prev_len))
        hold_bad++;
      prev_hold = 0;
      if (done_o) begin
        got_done = 1; got_bytes = done_bytes_o; got_flags = err_flags_o;
        break;
      end
      if (req_valid_o) begin
        if (n_req == err_after) rd_err_i = 1'b1;
        else if (req_ready_i) begin
          if (n_req < 16) begin
            got_addr[n_req] = req_addr_o; got_len[n_req] = req_len_o;
          end
          n_req++;
        end else begin
          prev_hold = 1; prev_addr = req_addr_o; prev_len = req_len_o;
        end
      end
      @(negedge clk);
    end
    rd_err_i = 1'b0; start_i = 1'b0; req_ready_i = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 valid", req_valid_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 flags", err_flags_o, 0);
  endtask

  localparam logic [159:0] SRC_LINE = {128'd0, 32'h1000_0000};
  localparam logic [95:0]  EXT_LINE = {64'd0, 32'h0ABC_0000};

  task automatic t_line_exact;
    // stride code 20 -> 320 bytes, line 100; noise control bits, bit 18 clear (R4)
    fire(32'h0028_03A5, 32'd300, (32'd20 << 18) | 32'd100, SRC_LINE, EXT_LINE);
    collect(-1, 32'd0, 0);
    chk("R3 count", n_req, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 addr", got_addr[i], 44'hABC_1000_0000 + 44'(i * 320));
      chk("R2 len", got_len[i], 100);
    end
    chk("R7 done", got_done, 1);
    chk("R7 bytes", got_bytes, 300);
  endtask

  task automatic t_line_over;
    fire(32'h0000_0000, 32'd250, (32'd20 << 18) | 32'd100, SRC_LINE, EXT_LINE);
    collect(-1, 32'd0, 0);
    chk("R3 overshoot count", n_req, 3);
    chk("R3 last full line", got_len[2], 100);
    chk("R3 bytes", got_bytes, 300);
  endtask

  localparam logic [159:0] SRC_FRAG = {32'h5000_0010, 32'h4000_0FFF, 32'h3000_0800,
                                       32'h2000_0000, 32'h0000_0F00};
  localparam logic [95:0]  EXT_FRAG = {32'h0005_0004, 32'h0003_0002, 32'h0001_0000};

  task automatic t_frag(input logic [31:0] size, input int exp_n, input logic [31:0] exp_bytes);
    logic [43:0] ea [5];
    logic [17:0] el [5];
    ea[0] = 44'h001_0000_0F00; el[0] = 256;
    ea[1] = 44'h002_2000_0000; el[1] = 4096;
    ea[2] = 44'h003_3000_0800; el[2] = 2048;
    ea[3] = 44'h004_4000_0FFF; el[3] = 1;
    ea[4] = 44'h005_5000_0010; el[4] = 4080;
    fire(32'h0004_00A5, size, (32'd3 << 18) | 32'd7, SRC_FRAG, EXT_FRAG);
    collect(-1, 32'd0, 0);
    chk("R6 count", n_req, exp_n);
    for (int i = 0; i < exp_n && i < n_req; i++) begin
      chk("R5 addr", got_addr[i], ea[i]);
      chk("R5 len", got_len[i], el[i]);
    end
    chk("R7 bytes", got_bytes, exp_bytes);
  endtask

  task automatic t_zero;
    fire(32'h0000_0000, 32'd0, (32'd1 << 18) | 32'd64, SRC_LINE, EXT_LINE);
    collect(-1, 32'd0, 0);
    chk("R7 zero line count", n_req, 0);
    chk("R7 zero done", got_done, 1);
    chk("R7 zero bytes", got_bytes, 0);
    chk("R9 flags cleared", got_flags, 0);
    fire(32'h0004_0000, 32'd0, 32'd0, SRC_FRAG, EXT_FRAG);
    collect(-1, 32'd0, 0);
    chk("R7 zero frag count", n_req, 0);
    chk("R7 zero frag bytes", got_bytes, 0);
  endtask

  task automatic t_line_len_zero;
    fire(32'h0000_0000, 32'd500, (32'd5 << 18), SRC_LINE, EXT_LINE);
    collect(-1, 32'd0, 0);
    chk("R10 count", n_req, 0);
    chk("R10 done", got_done, 1);
    chk("R10 bytes", got_bytes, 0);
  endtask

  task automatic t_stall;
    fire(32'h0000_0000, 32'd200, (32'd1 << 18) | 32'd100, SRC_LINE, EXT_LINE);
    collect(-1, 32'b0_1101_1011, 1);
    chk("R8 hold", hold_bad, 0);
    chk("R11 count", n_req, 2);
    chk("R11 addr0", got_addr[0], 44'hABC_1000_0000);
    chk("R11 addr1", got_addr[1], 44'hABC_1000_0010);
    chk("R11 bytes", got_bytes, 200);
  endtask

  task automatic t_error;
    fire(32'h0000_0000, 32'd400, (32'd20 << 18) | 32'd100, SRC_LINE, EXT_LINE);
    collect(1, 32'd0, 0);
    chk("R9 count", n_req, 1);
    chk("R9 done", got_done, 1);
    chk("R9 bytes", got_bytes, 100);
    chk("R9 flag", got_flags, 32'h1 << (12 + CH));
    @(negedge clk);
    chk("R9 idle after abort", req_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; ctrl_i = '0; xfer_size_i = '0;
    line_word_i = '0; src_addr_i = '0; ext_word_i = '0;
    req_ready_i = 1'b1; rd_err_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_line_exact;
    t_line_over;
    t_frag(32'd5000, 3, 32'd6400);
    t_frag(32'd6400, 3, 32'd6400);
    t_frag(32'd100000, 5, 32'd10481);
    t_error;
    t_zero;
    t_line_len_zero;
    t_stall;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule